// File: doc/BRIEF.md
# Store Address Generation Unit

This unit sits in the store path of a processor pipeline. Each cycle it can accept one 32-bit store instruction word, together with the current value of the base general register that the word names and the current stack-pointer value. It decodes the access size, the source register file and the addressing form, then computes the effective memory address. When the form updates its base, the unit also computes the new base value.

One cycle after the handshake, the unit presents its results. These are a memory write request (address, byte count, source register index and file select) and a base writeback request (general register index or stack pointer, plus the new value). It also raises an alignment-fault flag or an undefined-encoding flag when either applies. Three addressing forms are handled:

- an unsigned offset that is scaled by the access size, with no writeback;
- a pre-indexed form with a signed, unscaled offset;
- a post-indexed form with a signed, unscaled offset.

In the pre-indexed form the access uses the updated address. In the post-indexed form the access uses the old base and the sum is written back afterwards. Condition flags are never involved.

Top module: `store_agu`

## Requirements
- R1: The access byte count follows bits [31:30]: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. A word with bit 26 = 1, bits [31:30] = 00 and bits [23:22] = 10 gives 16. Every other accepted store uses bits [23:22] = 00.
- R2: When bits [25:24] = 01, the address is the base plus the zero-extended field in bits [21:10], shifted left by log2 of the byte count. No writeback is requested.
- R3: When bits [25:24] = 00, bit 21 = 0 and bits [11:10] = 11, bits [20:12] are sign-extended without scaling. Both the address and the writeback value equal the base plus this offset.
- R4: When bits [25:24] = 00, bit 21 = 0 and bits [11:10] = 01, the address is the unmodified base. The writeback value is the base plus the sign-extended, unscaled bits [20:12].
- R5: A base field (bits [9:5]) of 31 takes the base from the stack-pointer input, and any writeback then targets the stack pointer (wb_to_sp = 1, wb_idx = 31). Any other value takes the base from base_val and writes back to that general register.
- R6: With a base field of 31 and a nonzero sp_val[3:0], align_fault is raised and neither a memory request nor a writeback is issued.
- R7: The source register index is bits [4:0]. Bit 26 = 1 selects the floating-point/vector file (mem_src_fp = 1), and bit 26 = 0 selects the integer file.
- R8: The undefined flag is raised, with no request and no alignment fault, in any of these cases: bits [29:27] are not 111; bits [25:24] are 10 or 11; the indexed form has bit 21 = 1 or bits [11:10] of 00 or 10; or bits [23:22] differ from 00 and the word is not the 16-byte pattern of R1.
- R9: An instruction is accepted when in_valid and in_ready are both high. in_ready is high in every cycle after reset. For each accepted instruction, out_valid is high for exactly one cycle, on the clock edge that follows acceptance.
- R10: During synchronous active-low reset, out_valid, mem_req, wb_req, align_fault, undef and in_ready are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept a word |
| instr | input | 32 | Store instruction word |
| base_val | input | 64 | Value of the general register named by bits [9:5] |
| sp_val | input | 64 | Current stack-pointer value |
| out_valid | output | 1 | Result fields valid this cycle |
| mem_req | output | 1 | Memory write requested |
| mem_addr | output | 64 | Effective address |
| mem_bytes | output | 5 | Bytes to write (1, 2, 4, 8 or 16) |
| mem_src_idx | output | 5 | Source register index |
| mem_src_fp | output | 1 | Source is the floating-point/vector file |
| wb_req | output | 1 | Base writeback requested |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_value | output | 64 | New base value |
| align_fault | output | 1 | Stack-pointer alignment fault |
| undef | output | 1 | Unrecognised encoding |

## Verification
The assertions check the following on every cycle:
- an undefined or faulting result never carries a request, and a writeback never appears without a memory access;
- a requested byte count is always a power of two;
- a stack-pointer writeback always names index 31;
- out_valid only follows a completed handshake.

Only the scoreboard scenarios can show that the arithmetic is correct. This covers the scaled offset for each size and the sign extension of negative indexed offsets. It also covers the different address order of the pre- and post-indexed forms, the choice between the stack pointer and base_val, and the exact set of encodings that counts as undefined.

// File: rtl/store_agu_pkg.sv
// Package: shared widths and decode types for the store address unit.
// Assumes 32-bit instruction words and 5-bit register indices.
package store_agu_pkg;

    localparam int INSTR_W = 32;
    localparam int RIDX_W  = 5;
    localparam int IMMU_W  = 12;
    localparam int IMMS_W  = 9;
    localparam int LG_W    = 3;

    typedef enum logic [1:0] {
        FORM_UOFF = 2'd0,
        FORM_POST = 2'd1,
        FORM_PRE  = 2'd2,
        FORM_BAD  = 2'd3
    } agu_form_e;

    typedef struct packed {
        logic              bad;
        agu_form_e         form;
        logic [LG_W-1:0]   lg_bytes;
        logic              fp;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rt;
        logic [IMMU_W-1:0] imm_u;
        logic [IMMS_W-1:0] imm_s;
    } agu_dec_t;

endpackage

// File: rtl/store_agu_decode.sv
// Module: store_agu_decode
// Purely combinational field decode of a store word: size, register file,
// addressing form and immediates. Flags every pattern it does not accept.
// Assumes: the caller qualifies the result with its own handshake.
module store_agu_decode
    import store_agu_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output agu_dec_t           dec
);

    logic [1:0] sz;
    logic [1:0] cls;
    logic [1:0] opc;
    logic       vec;
    logic       fam_ok;
    logic       wide;
    logic       opc_ok;
    agu_form_e  form;

    // Split the word into the fields that steer the decode.
    always_comb begin
        sz     = word[31:30];
        fam_ok = (word[29:27] == 3'b111);
        vec    = word[26];
        cls    = word[25:24];
        opc    = word[23:22];
    end

    // Size qualifier: only the 16-byte vector pattern may use a nonzero opc.
    always_comb begin
        wide   = vec && (sz == 2'b00) && (opc == 2'b10);
        opc_ok = (opc == 2'b00) || wide;
    end

    // Addressing form selection from the class bits and the index-mode bits.
    always_comb begin
        form = FORM_BAD;
        if (cls == 2'b01) begin
            form = FORM_UOFF;
        end else if (cls == 2'b00 && !word[21] && word[10]) begin
            form = word[11] ? FORM_PRE : FORM_POST;
        end
    end

    // Assemble the decoded record.
    always_comb begin
        dec.bad      = !fam_ok || !opc_ok || (form == FORM_BAD);
        dec.form     = form;
        dec.lg_bytes = wide ? LG_W'(4) : {1'b0, sz};
        dec.fp       = vec;
        dec.rn       = word[9:5];
        dec.rt       = word[4:0];
        dec.imm_u    = word[21:10];
        dec.imm_s    = word[20:12];
    end

endmodule

// File: rtl/store_agu_addr.sv
// Module: store_agu_addr
// Selects the base (general register or stack pointer), builds the offset
// for the decoded form, and produces the access address and new base value.
// Assumes: dec is valid only when dec.bad is low; outputs are don't-care otherwise.
module store_agu_addr
    import store_agu_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  agu_dec_t          dec,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] sp_val,
    output logic              use_sp,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] new_base
);

    localparam logic [RIDX_W-1:0] SP_IDX = '1;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off_u;
    logic [ADDR_W-1:0] off_s;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;

    // Base source: index 31 names the stack pointer.
    always_comb begin
        use_sp = (dec.rn == SP_IDX);
        base   = use_sp ? sp_val : base_val;
    end

    // Offsets: unsigned field scaled by size, signed field taken as is.
    always_comb begin
        off_u  = {{(ADDR_W-IMMU_W){1'b0}}, dec.imm_u} << dec.lg_bytes;
        off_s  = {{(ADDR_W-IMMS_W){dec.imm_s[IMMS_W-1]}}, dec.imm_s};
        offset = (dec.form == FORM_UOFF) ? off_u : off_s;
        sum    = base + offset;
    end

    // Ordering: post-index accesses the old base, the other forms the sum.
    always_comb begin
        acc_addr = (dec.form == FORM_POST) ? base : sum;
        new_base = sum;
    end

endmodule

// File: rtl/store_agu_align.sv
// Module: store_agu_align
// Stack-pointer alignment check, applied only when the base is the stack pointer.
// Assumes: ALIGN_LG is at least 1 and below ADDR_W.
module store_agu_align #(
    parameter int ADDR_W   = 64,
    parameter int ALIGN_LG = 4
) (
    input  logic              use_sp,
    input  logic [ADDR_W-1:0] sp_val,
    output logic              fault
);

    // Any low bit set in the stack pointer is a misaligned base.
    always_comb begin
        fault = use_sp && (|sp_val[ALIGN_LG-1:0]);
    end

endmodule

// File: rtl/store_agu.sv
// Module: store_agu (top)
// Accepts one store word per cycle through valid/ready and registers the
// memory request, base writeback, alignment fault and undefined flag.
// Assumes: base_val already holds the register named by bits [9:5].
module store_agu
    import store_agu_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int ALIGN_LG = 4,
    parameter int BYTES_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [ADDR_W-1:0]   sp_val,
    output logic                out_valid,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTES_W-1:0]  mem_bytes,
    output logic [RIDX_W-1:0]   mem_src_idx,
    output logic                mem_src_fp,
    output logic                wb_req,
    output logic                wb_to_sp,
    output logic [RIDX_W-1:0]   wb_idx,
    output logic [ADDR_W-1:0]   wb_value,
    output logic                align_fault,
    output logic                undef
);

    localparam logic [BYTES_W-1:0] ONE_BYTE = BYTES_W'(1);

    agu_dec_t          dec;
    logic              use_sp;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] new_base;
    logic              sp_fault;
    logic              ready_q;
    logic              take;
    logic              good;

    store_agu_decode u_decode (
        .word (instr),
        .dec  (dec)
    );

    store_agu_addr #(.ADDR_W(ADDR_W)) u_addr (
        .dec      (dec),
        .base_val (base_val),
        .sp_val   (sp_val),
        .use_sp   (use_sp),
        .acc_addr (acc_addr),
        .new_base (new_base)
    );

    store_agu_align #(.ADDR_W(ADDR_W), .ALIGN_LG(ALIGN_LG)) u_align (
        .use_sp (use_sp),
        .sp_val (sp_val),
        .fault  (sp_fault)
    );

    assign in_ready = ready_q;

    // Handshake qualification and request gating.
    always_comb begin
        take = in_valid && ready_q;
        good = !dec.bad && !sp_fault;
    end

    // Readiness: low in reset, high from the first cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Control flags: one-cycle pulses per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            mem_req     <= 1'b0;
            wb_req      <= 1'b0;
            align_fault <= 1'b0;
            undef       <= 1'b0;
        end else begin
            out_valid   <= take;
            mem_req     <= take && good;
            wb_req      <= take && good && (dec.form != FORM_UOFF);
            align_fault <= take && !dec.bad && sp_fault;
            undef       <= take && dec.bad;
        end
    end

    // Data fields: captured on acceptance, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr    <= '0;
            mem_bytes   <= '0;
            mem_src_idx <= '0;
            mem_src_fp  <= 1'b0;
            wb_to_sp    <= 1'b0;
            wb_idx      <= '0;
            wb_value    <= '0;
        end else if (take) begin
            mem_addr    <= acc_addr;
            mem_bytes   <= ONE_BYTE << dec.lg_bytes;
            mem_src_idx <= dec.rt;
            mem_src_fp  <= dec.fp;
            wb_to_sp    <= use_sp;
            wb_idx      <= dec.rn;
            wb_value    <= new_base;
        end
    end

    AST_BYTES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_bytes) == 1)); // R1
    AST_WB_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> mem_req); // R2
    AST_SP_TARGET_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_to_sp) |-> (wb_idx == 5'd31)); // R5
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!mem_req && !wb_req && out_valid)); // R6
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!mem_req && !wb_req && !align_fault && out_valid)); // R8
    AST_ONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready)); // R9
    AST_REQ_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || wb_req) |-> out_valid); // R9

endmodule

// File: tb/store_agu_bench.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module store_agu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] instr = '0;
    logic [63:0] base_val = '0;
    logic [63:0] sp_val = '0;
    logic        out_valid, mem_req, mem_src_fp, wb_req, wb_to_sp, align_fault, undef;
    logic [63:0] mem_addr, wb_value;
    logic [4:0]  mem_bytes, mem_src_idx, wb_idx;

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic        und;
        logic        flt;
        logic        mem;
        logic        wb;
        logic [63:0] addr;
        logic [4:0]  bytes;
        logic [4:0]  src;
        logic        fp;
        logic        to_sp;
        logic [4:0]  widx;
        logic [63:0] wval;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    store_agu u_store_agu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .base_val(base_val), .sp_val(sp_val),
        .out_valid(out_valid), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_src_idx(mem_src_idx), .mem_src_fp(mem_src_fp),
        .wb_req(wb_req), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx), .wb_value(wb_value),
        .align_fault(align_fault), .undef(undef)
    );

    function automatic logic [31:0] enc_u(input logic [1:0] sz, input logic v,
        input logic [1:0] opc, input logic [11:0] imm, input logic [4:0] rn, input logic [4:0] rt);
        return {sz, 3'b111, v, 2'b01, opc, imm, rn, rt};
    endfunction

    function automatic logic [31:0] enc_i(input logic [1:0] sz, input logic v,
        input logic [1:0] opc, input logic [8:0] imm, input logic [1:0] md,
        input logic [4:0] rn, input logic [4:0] rt);
        return {sz, 3'b111, v, 2'b00, opc, 1'b0, imm, md, rn, rt};
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] w, input logic [63:0] b, input logic [63:0] sp);
        exp_t e;
        int   lg;
        logic bad, is16, pre, post, uns;
        logic [63:0] base, off;
        e = '0;
        is16 = w[26] && w[31:30] == 2'b00 && w[23:22] == 2'b10;
        lg   = is16 ? 4 : int'(w[31:30]);
        uns  = w[25:24] == 2'b01;
        pre  = w[25:24] == 2'b00 && !w[21] && w[11:10] == 2'b11;
        post = w[25:24] == 2'b00 && !w[21] && w[11:10] == 2'b01;
        bad  = (w[29:27] != 3'b111) || !(uns || pre || post) || !(w[23:22] == 2'b00 || is16);
        base = (w[9:5] == 5'd31) ? sp : b;
        if (uns) off = 64'(w[21:10]) * (64'd1 << lg);
        else     off = {{55{w[20]}}, w[20:12]};
        e.und = bad;
        e.flt = !bad && w[9:5] == 5'd31 && sp[3:0] != 4'd0;
        e.mem = !bad && !e.flt;
        e.wb  = e.mem && !uns;
        e.addr  = post ? base : base + off;
        e.bytes = 5'(1 << lg);
        e.src   = w[4:0];
        e.fp    = w[26];
        e.to_sp = w[9:5] == 5'd31;
        e.widx  = w[9:5];
        e.wval  = base + off;
        return e;
    endfunction

    task automatic send(input logic [31:0] w, input logic [63:0] b, input logic [63:0] sp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = w;
        base_val = b;
        sp_val   = sp;
        expq.push_back(model(w, b, sp));
        tagq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr    = $urandom;
        end
    endtask

    // Monitor: compare each result slot against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected out_valid, actual=1 expected=0");
            end else begin
                exp_t  e;
                string t;
                logic  ok;
                e = expq.pop_front();
                t = tagq.pop_front();
                ok = (undef == e.und) && (align_fault == e.flt) &&
                     (mem_req == e.mem) && (wb_req == e.wb);
                if (e.mem) ok = ok && mem_addr == e.addr && mem_bytes == e.bytes &&
                                mem_src_idx == e.src && mem_src_fp == e.fp;
                if (e.wb)  ok = ok && wb_to_sp == e.to_sp && wb_idx == e.widx &&
                                wb_value == e.wval;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: actual u%0b f%0b m%0b w%0b a=%h n=%0d s=%0d fp=%0b sp=%0b i=%0d v=%h expected u%0b f%0b m%0b w%0b a=%h n=%0d s=%0d fp=%0b sp=%0b i=%0d v=%h",
                        t, undef, align_fault, mem_req, wb_req, mem_addr, mem_bytes, mem_src_idx,
                        mem_src_fp, wb_to_sp, wb_idx, wb_value,
                        e.und, e.flt, e.mem, e.wb, e.addr, e.bytes, e.src, e.fp, e.to_sp, e.widx, e.wval);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R10 reset state
        if (out_valid || mem_req || wb_req || align_fault || undef || in_ready) begin
            errors++;
            $display("FAIL R10: actual flags=%b expected=000000",
                {out_valid, mem_req, wb_req, align_fault, undef, in_ready});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++; // R9 ready after reset
        if (in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R9: in_ready actual=%b expected=1", in_ready);
        end

        send(32'hB900_0000 | enc_u(2'b10, 1'b0, 2'b00, 12'd4, 5'd1, 5'd3), 64'h1000, 64'h0, "R2_word");
        send(enc_u(2'b00, 1'b0, 2'b00, 12'hFFF, 5'd4, 5'd7), 64'h2000, 64'h0, "R1_byte");
        send(enc_u(2'b01, 1'b0, 2'b00, 12'd3, 5'd5, 5'd8), 64'h3000, 64'h0, "R1_half");
        send(enc_u(2'b11, 1'b0, 2'b00, 12'd5, 5'd6, 5'd9), 64'h4000, 64'h0, "R1_dword");
        send(enc_u(2'b00, 1'b1, 2'b10, 12'd2, 5'd7, 5'd10), 64'h5000, 64'h0, "R1_quad");
        send(enc_u(2'b10, 1'b1, 2'b00, 12'd1, 5'd8, 5'd30), 64'h6000, 64'h0, "R7_fp");
        idle(2);
        send(enc_i(2'b11, 1'b0, 2'b00, 9'h1F0, 2'b11, 5'd2, 5'd11), 64'h7000, 64'h0, "R3_pre_neg");
        send(enc_i(2'b10, 1'b0, 2'b00, 9'd255, 2'b01, 5'd3, 5'd12), 64'h8000, 64'h0, "R4_post");
        send(enc_i(2'b01, 1'b1, 2'b00, 9'h100, 2'b01, 5'd9, 5'd13), 64'h9000, 64'h0, "R4_post_neg");
        send(enc_i(2'b11, 1'b0, 2'b00, 9'd16, 2'b11, 5'd31, 5'd1), 64'hDEAD, 64'h8000, "R5_sp_pre");
        send(enc_i(2'b11, 1'b0, 2'b00, 9'd8, 2'b01, 5'd31, 5'd1), 64'h0, 64'h8004, "R6_post_fault");
        send(enc_u(2'b10, 1'b0, 2'b00, 12'd1, 5'd31, 5'd2), 64'h0, 64'h8008, "R6_uoff_fault");
        send(enc_u(2'b10, 1'b0, 2'b00, 12'd3, 5'd31, 5'd2), 64'hFFFF, 64'h9000, "R5_sp_uoff");
        send(enc_u(2'b10, 1'b0, 2'b00, 12'd1, 5'd1, 5'd2) & ~32'h0800_0000, 64'h0, 64'h0, "R8_family");
        send(enc_i(2'b11, 1'b0, 2'b00, 9'd4, 2'b00, 5'd1, 5'd2), 64'h0, 64'h0, "R8_mode00");
        send(enc_i(2'b11, 1'b0, 2'b00, 9'd4, 2'b10, 5'd1, 5'd2), 64'h0, 64'h0, "R8_mode10");
        send(enc_u(2'b10, 1'b0, 2'b10, 12'd1, 5'd1, 5'd2), 64'h0, 64'h0, "R8_int_opc");
        send(enc_u(2'b01, 1'b1, 2'b10, 12'd1, 5'd1, 5'd2), 64'h0, 64'h0, "R8_wide_size");
        send(enc_i(2'b11, 1'b0, 2'b00, 9'd4, 2'b11, 5'd1, 5'd2) | 32'h0020_0000, 64'h0, 64'h0, "R8_bit21");
        send(enc_u(2'b10, 1'b0, 2'b00, 12'd1, 5'd1, 5'd2) | 32'h0200_0000, 64'h0, 64'h0, "R8_class11");
        send(enc_i(2'b10, 1'b0, 2'b01, 9'd4, 2'b01, 5'd31, 5'd2), 64'h0, 64'h8001, "R8_over_R6");
        idle(4);

        checks++; // R9 every accepted word produced exactly one result
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R9: pending results actual=%0d expected=0", expq.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule